// File: doc/BRIEF.md
# Sequential Rotate-Right Shifter

This block rotates a 4-bit word to the right by 0 to 3 positions. A small control state machine drives a register datapath, so there is no single-cycle multiplexer tree. When a start strobe is accepted, the block captures the input word into a working register and captures the rotate count into a down-counter. The register then moves right by one position on each clock. On every step, the bit that leaves the low end re-enters at the high end. When the count reaches zero, the result is flagged valid and held.

Latency depends on the rotate count: one cycle to load, plus one cycle for each single-position step. While the block is rotating it reports itself busy and ignores further start strobes. A finished result stays on the output, and valid stays high, until the next accepted start.

Top module: `rotr_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears result to 0 and drives busy and valid low.
- R2: Start is accepted when start is high and busy is low at a clock edge. On acceptance the block loads data_in into result. If amount is nonzero, busy is high and valid is low after that edge.
- R3: On each clock edge while busy is high, result is rotated right by exactly one position. The new value is {result[0], result[3:1]}, where bit 3 is the MSB.
- R4: With input bits I3 I2 I1 I0 (MSB first), the final result depends on amount. Amount 2'b01 gives I0 I3 I2 I1. Amount 2'b10 gives I1 I0 I3 I2. Amount 2'b11 gives I2 I1 I0 I3.
- R5: Amount 2'b00 passes data_in through unchanged, and valid is high directly after the accepting edge.
- R6: Valid first goes high after amount+1 clock edges, counting the accepting edge as the first. Busy and valid are never high together.
- R7: A start strobe that arrives while busy is high is ignored. The rotation in progress and its final result are unaffected.
- R8: Once valid is high, valid and result stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to load a word and begin rotating |
| data_in | input | 4 | Word to be rotated |
| amount | input | 2 | Number of right-rotate positions, 0 to 3 |
| result | output | 4 | Working register; holds the final rotated word |
| busy | output | 1 | High while rotate steps remain |
| valid | output | 1 | High when result holds a finished rotation |

## Verification
The assertions assume that reset is held low for at least one clock edge before any check applies. They also assume that start, data_in and amount are settled at each rising edge. They do not assume that start stays low while the block is busy. The scoreboard drives every input on the falling edge and releases start one cycle after raising it. One directed case deliberately raises start with a different word and count during a rotation, so that the ignore rule is exercised.

// File: rtl/rotr_pkg.sv
// Package: shared types for the sequential rotate-right shifter.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package rotr_pkg;

    // Controller phases: waiting, stepping, holding a finished result.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ROTATE = 2'd1,
        PH_HOLD   = 2'd2
    } phase_t;

    // Control bundle passed from controller to datapath.
    typedef struct packed {
        logic load;
        logic step;
    } dp_ctrl_t;

endpackage

// File: rtl/rotr_ctrl.sv
// Module: rotr_ctrl
// Sequences one load cycle followed by one step per remaining count.
// Assumes amount is sampled only on the accepting edge; start is ignored
// while the phase is PH_ROTATE.
module rotr_ctrl
    import rotr_pkg::*;
#(
    parameter int AMT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AMT_W-1:0] amount,
    output dp_ctrl_t         ctrl,
    output logic             busy,
    output logic             valid
);

    localparam logic [AMT_W-1:0] ONE = {{(AMT_W-1){1'b0}}, 1'b1};

    phase_t           phase;
    logic [AMT_W-1:0] remain;
    logic             accept;

    // Start is honoured only outside the stepping phase.
    always_comb begin
        accept = start && (phase != PH_ROTATE);
    end

    // Control outputs decoded from the phase.
    always_comb begin
        ctrl.load = accept;
        ctrl.step = (phase == PH_ROTATE);
        busy      = (phase == PH_ROTATE);
        valid     = (phase == PH_HOLD);
    end

    // Phase and step-count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else if (accept) begin
            remain <= amount;
            phase  <= (amount == '0) ? PH_HOLD : PH_ROTATE;
        end else if (phase == PH_ROTATE) begin
            remain <= remain - ONE;
            if (remain == ONE) begin
                phase <= PH_HOLD;
            end
        end
    end

endmodule

// File: rtl/rotr_dp.sv
// Module: rotr_dp
// Working register that either loads a word or rotates right by one.
// Assumes load and step are never requested together.
module rotr_dp
    import rotr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dp_ctrl_t         ctrl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] rotated;

    // Single-position right rotate: the low bit wraps to the top.
    always_comb begin
        rotated = {q[0], q[WIDTH-1:1]};
    end

    // Register update: load has priority, otherwise step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ctrl.load) begin
            q <= din;
        end else if (ctrl.step) begin
            q <= rotated;
        end
    end

endmodule

// File: rtl/rotr_seq.sv
// Module: rotr_seq (top)
// Multi-cycle rotate-right shifter: controller plus register datapath.
// Assumes a single clock domain and a synchronous active-low reset.
module rotr_seq
    import rotr_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    output logic [WIDTH-1:0] result,
    output logic             busy,
    output logic             valid
);

    dp_ctrl_t ctrl;

    rotr_ctrl #(.AMT_W(AMT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .amount (amount),
        .ctrl   (ctrl),
        .busy   (busy),
        .valid  (valid)
    );

    rotr_dp #(.WIDTH(WIDTH)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl),
        .din   (data_in),
        .q     (result)
    );

endmodule

// File: rtl/rotr_seq_chk.sv
// Module: rotr_seq_chk
// Port-level protocol checks for rotr_seq, attached by bind.
// Assumes reset is held low for at least one edge before checks matter.
module rotr_seq_chk #(
    parameter int WIDTH = 4,
    parameter int AMT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] data_in,
    input logic [AMT_W-1:0] amount,
    input logic [WIDTH-1:0] result,
    input logic             busy,
    input logic             valid
);

    a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && amount != '0) |=> (busy && !valid && result == $past(data_in)));

    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (result == {$past(result[0]), $past(result[WIDTH-1:1])}));

    a_r5_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && amount == '0) |=> (valid && result == $past(data_in)));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && valid));

    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || valid));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> (valid && $stable(result)));

endmodule

bind rotr_seq rotr_seq_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .data_in (data_in),
    .amount  (amount),
    .result  (result),
    .busy    (busy),
    .valid   (valid)
);

// File: tb/sim_rotr_seq.sv
module sim_rotr_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [3:0] exp;
        int         amt;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] data_in = '0;
    logic [1:0] amount = '0;
    logic [3:0] result;
    logic       busy;
    logic       valid;

    int    n_tests = 0;
    int    n_fail  = 0;
    item_t sb[$];
    bit    mon_idle = 1'b1;

    rotr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
        .amount(amount), .result(result), .busy(busy), .valid(valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: combinational right rotate.
    function automatic logic [3:0] ref_rot(logic [3:0] d, int a);
        logic [3:0] r = d;
        for (int i = 0; i < a; i++) r = {r[0], r[3:1]};
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: issue one start and push the expected result.
    task automatic drive(logic [3:0] d, int a, string tag);
        item_t it;
        it.exp = ref_rot(d, a);
        it.amt = a;
        it.tag = tag;
        data_in = d;
        amount  = 2'(a);
        start   = 1'b1;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        repeat (a) @(negedge clk);
    endtask

    // Monitor: pop each expected item and compare at its latency.
    initial begin
        forever begin
            item_t it;
            wait (sb.size() > 0);
            mon_idle = 1'b0;
            it = sb.pop_front();
            for (int c = 1; c <= it.amt + 1; c++) begin
                @(negedge clk);
                if (c <= it.amt) check({"R6 not yet valid ", it.tag}, {31'd0, valid}, 32'd0);
                if (c == 1 && it.amt > 0) check({"R2 busy ", it.tag}, {31'd0, busy}, 32'd1);
            end
            check({"R6 valid ", it.tag}, {31'd0, valid}, 32'd1);
            check({"R6 busy low ", it.tag}, {31'd0, busy}, 32'd0);
            check({"R4 result ", it.tag}, {28'd0, result}, {28'd0, it.exp});
            mon_idle = 1'b1;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 result", {28'd0, result}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 valid", {31'd0, valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 ordering with a walking one: amount 1 moves bit0 to bit3.
        drive(4'b0001, 1, "R4 a1");
        drive(4'b0010, 2, "R4 a2");
        drive(4'b0100, 3, "R4 a3");
        drive(4'b1011, 0, "R5 pass");

        // Exhaustive sweep of words and amounts (R3 stepping).
        for (int d = 0; d < 16; d++)
            for (int a = 0; a < 4; a++)
                drive(4'(d), a, "R3 sweep");
        wait (mon_idle && sb.size() == 0);

        // R8: hold with no start for several cycles.
        drive(4'b1100, 2, "R8 setup");
        wait (mon_idle && sb.size() == 0);
        repeat (5) @(negedge clk);
        check("R8 valid held", {31'd0, valid}, 32'd1);
        check("R8 result held", {28'd0, result}, {28'd0, ref_rot(4'b1100, 2)});

        // R7: start while busy with other word and amount is ignored.
        begin
            item_t it;
            it.exp = ref_rot(4'b1001, 3);
            it.amt = 3;
            it.tag = "R7 ignore";
            data_in = 4'b1001; amount = 2'd3; start = 1'b1;
            sb.push_back(it);
            @(negedge clk);
            data_in = 4'b0110; amount = 2'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
        end
        wait (mon_idle && sb.size() == 0);
        @(negedge clk);
        check("R7 result after ignored start", {28'd0, result}, {28'd0, ref_rot(4'b1001, 3)});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule